// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Front End

This block is the synchronous front end of a single-data-rate burst SRAM with a small on-chip array. All control inputs are sampled on the rising clock edge. An access begins with either of two address strobes. The processor-side strobe has priority over the controller-side strobe, and the two follow different rules for their write inputs. After the start, a two-bit wrapping burst counter walks through the aligned group of four words. The walk is linear or interleaved, depending on an order pin that is latched when the access starts.

Writes are qualified over four byte lanes. A global write stores every lane. Without it, a byte write stores only the lanes whose selects are active. The shared data bus is modelled as separate data-in, data-out and drive-enable signals. The drive enable is removed at once whenever the write inputs indicate a write, and it follows the asynchronous output enable.

The control is a three-state machine. ST_IDLE holds no address. ST_LEAD means an address was latched at the last edge. ST_BEAT means the burst is in progress. The transitions are:
- START: any state goes to ST_LEAD on a qualified strobe with all chip selects active.
- DESELECT: ST_LEAD or ST_BEAT goes to ST_IDLE on a qualified strobe while the selects are not all active.
- CONTINUE: ST_LEAD or ST_BEAT goes to ST_BEAT on an edge with no qualified strobe.
- IDLE_HOLD: ST_IDLE stays in ST_IDLE when there is neither a start nor a continuation.

Top module: `burst_sram_ctrl`

## Requirements
- R1: An access starts only when sel0_n is low, sel1 is high, sel2_n is low and a strobe qualifies. A qualified strobe without all three selects deselects the block. In the following cycle dout_en is low, and later edges with no strobe neither write nor read until the next start.
- R2: The processor strobe (proc_strobe_n low) is ignored while sel0_n is high.
- R3: The controller strobe is ignored in any cycle where proc_strobe_n is low. Its write inputs then cause no write.
- R4: A controller-strobe start with all write inputs inactive is a read. The word at the start address is on dout with dout_en high after the first edge following the start edge.
- R5: At a processor-strobe start, the write inputs are ignored in the start cycle. A write indicated at the next edge stores din at the start address.
- R6: A controller-strobe start with a write indicated stores din at addr on that same edge.
- R7: At a start, the burst offset loads addr[1:0]. At each following edge with no strobe, the offset steps if adv_n is low and holds if adv_n is high. Each access uses the current offset. The upper address bits never change during a burst, so the burst wraps inside the aligned group of four.
- R8: With burst_ilv low at the start, beat n uses offset (start + n) mod 4.
- R9: With burst_ilv high at the start, beat n uses offset start XOR n. For example, start 01 gives 01, 00, 11, 10.
- R10: With glob_wr_n low, all four lanes are written, whatever byte_wr_en_n and lane_sel_n are.
- R11: With glob_wr_n high, lane k (din bits 8k+7 to 8k) is written only when byte_wr_en_n is low and lane_sel_n[k] is low. Other lanes keep their contents.
- R12: dout_en is low, within the same cycle and regardless of oe_n, whenever glob_wr_n is low or byte_wr_en_n is low with at least one lane_sel_n bit low.
- R13: dout_en is high only while oe_n is low. It follows oe_n without waiting for a clock edge.
- R14: During reset and after it, the block is in ST_IDLE and dout_en is low until a read has been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | ADDR_W | Word address |
| proc_strobe_n | input | 1 | Processor-side address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select 0, active low |
| sel1 | input | 1 | Chip select 1, active high |
| sel2_n | input | 1 | Chip select 2, active low |
| glob_wr_n | input | 1 | Global write, all lanes, active low |
| byte_wr_en_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | LANES | Per-lane byte select, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data from the bus |
| dout | output | LANES*LANE_W | Read data to the bus (zero when not driven) |
| dout_en | output | 1 | Bus drive enable |

## Verification
The bench fills the whole array. It then runs four-beat bursts from every start address in both orders, so a design that ignored the wrap or mixed up the linear and XOR sequences would return a word from the wrong offset, or from the neighbouring group. It sweeps all sixteen lane masks to catch a lane that is written although its select is inactive. It also checks that a global write overrides byte selects that are all inactive. Strobe priority and chip-select gating are checked through side effects on the memory. A design that honoured the controller strobe beside an active processor strobe, or took write inputs at a processor start, would corrupt a word the bench reads back later. A missing asynchronous tristate would show up as dout_en staying high while the write inputs or oe_n change between edges.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_BEAT = 2'd2
    } acc_state_e;

    function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                               input logic [1:0] n,
                                               input logic       ilv);
        return ilv ? (first ^ n) : (first + n);
    endfunction
endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_in,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [1:0]        cur_off
);
    import bsram_pkg::*;

    localparam int HI_W = ADDR_W - 2;

    logic [HI_W-1:0] hi_q;
    logic [1:0]      first_q;
    logic [1:0]      cnt_q;
    logic            ilv_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            first_q <= '0;
            cnt_q   <= '0;
            ilv_q   <= 1'b1;
        end else if (load) begin
            hi_q    <= addr_in[ADDR_W-1:2];
            first_q <= addr_in[1:0];
            cnt_q   <= '0;
            ilv_q   <= ilv_in;
        end else if (step) begin
            cnt_q   <= cnt_q + 2'd1;
        end
    end

    always_comb begin
        cur_off  = beat_offset(first_q, cnt_q, ilv_q);
        cur_addr = {hi_q, cur_off};
    end
endmodule

// File: rtl/bsram_lane_mem.sv
module bsram_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we_lane,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    re,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] arr [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (we_lane[g]) begin
                arr[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
            if (re) begin
                rd_q <= arr[raddr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = rd_q;
    end
endmodule

// File: rtl/bsram_access_fsm.sv
module bsram_access_fsm (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   p_valid,
    input  logic                   c_valid,
    input  logic                   sel_all,
    input  logic                   wr_req,
    input  logic                   adv_n,
    output logic                   load,
    output logic                   step,
    output logic                   wr_fire,
    output logic                   wr_from_port,
    output logic                   rd_fire,
    output logic                   rd_valid_q,
    output bsram_pkg::acc_state_e  state_q
);
    import bsram_pkg::*;

    acc_state_e state_d;
    logic       strobe, start, desel, cont;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            rd_valid_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= rd_fire;
        end
    end

    always_comb begin
        strobe       = p_valid | c_valid;
        start        = strobe & sel_all;
        desel        = strobe & ~sel_all;
        cont         = ~strobe & (state_q != ST_IDLE);
        load         = start;
        step         = cont & ~adv_n;
        wr_from_port = c_valid & sel_all;
        wr_fire      = (wr_from_port & wr_req) | (cont & wr_req);
        rd_fire      = (state_q != ST_IDLE) & ~wr_fire & ~desel;
        state_d      = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_LEAD : ST_IDLE;
            ST_LEAD,
            ST_BEAT: begin
                if (start)      state_d = ST_LEAD;
                else if (desel) state_d = ST_IDLE;
                else            state_d = ST_BEAT;
            end
            default: state_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_strobe_n,
    input  logic                    ctrl_strobe_n,
    input  logic                    adv_n,
    input  logic                    sel0_n,
    input  logic                    sel1,
    input  logic                    sel2_n,
    input  logic                    glob_wr_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    import bsram_pkg::*;

    localparam int DATA_W = LANES * LANE_W;

    logic              sel_all, p_valid, c_valid, wr_req;
    logic [LANES-1:0]  lane_mask, we_lane;
    logic              load, step, wr_fire, wr_from_port, rd_fire, rd_valid_q;
    logic [ADDR_W-1:0] cur_addr, waddr;
    logic [1:0]        cur_off;
    logic [DATA_W-1:0] rd_data;
    acc_state_e        fsm_state;

    always_comb begin
        sel_all   = ~sel0_n & sel1 & ~sel2_n;
        p_valid   = ~proc_strobe_n & ~sel0_n;
        c_valid   = ~ctrl_strobe_n & proc_strobe_n;
        lane_mask = ~glob_wr_n ? {LANES{1'b1}}
                  : (~byte_wr_en_n ? ~lane_sel_n : '0);
        wr_req    = |lane_mask;
        we_lane   = wr_fire ? lane_mask : '0;
        waddr     = wr_from_port ? addr : cur_addr;
        dout_en   = rd_valid_q & ~oe_n & ~wr_req;
        dout      = dout_en ? rd_data : '0;
    end

    bsram_access_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .p_valid      (p_valid),
        .c_valid      (c_valid),
        .sel_all      (sel_all),
        .wr_req       (wr_req),
        .adv_n        (adv_n),
        .load         (load),
        .step         (step),
        .wr_fire      (wr_fire),
        .wr_from_port (wr_from_port),
        .rd_fire      (rd_fire),
        .rd_valid_q   (rd_valid_q),
        .state_q      (fsm_state)
    );

    bsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_in  (addr),
        .ilv_in   (burst_ilv),
        .cur_addr (cur_addr),
        .cur_off  (cur_off)
    );

    bsram_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk     (clk),
        .we_lane (we_lane),
        .waddr   (waddr),
        .wdata   (din),
        .re      (rd_fire),
        .raddr   (cur_addr),
        .rdata   (rd_data)
    );
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [ADDR_W-1:0]     addr,
    input logic                  proc_strobe_n,
    input logic                  ctrl_strobe_n,
    input logic                  adv_n,
    input logic                  sel0_n,
    input logic                  sel1,
    input logic                  sel2_n,
    input logic                  glob_wr_n,
    input logic                  byte_wr_en_n,
    input logic [LANES-1:0]      lane_sel_n,
    input logic                  oe_n,
    input logic                  dout_en,
    input logic [1:0]            cur_off,
    input bsram_pkg::acc_state_e fsm_state
);
    import bsram_pkg::*;

    logic all_sel, any_strobe;
    assign all_sel    = ~sel0_n & sel1 & ~sel2_n;
    assign any_strobe = (~proc_strobe_n & ~sel0_n) | (~ctrl_strobe_n & proc_strobe_n);

    // R12
    wr_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_wr_n || (!byte_wr_en_n && lane_sel_n != '1)) |-> !dout_en);

    // R13
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    // R7
    offset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && all_sel) |=> cur_off == $past(addr[1:0]));

    // R7
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE && proc_strobe_n && ctrl_strobe_n && adv_n)
        |=> $stable(cur_off));

    // R7
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_IDLE && proc_strobe_n && ctrl_strobe_n && !adv_n)
        |=> cur_off != $past(cur_off));

    // R1
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_strobe && !all_sel) |=> (fsm_state == ST_IDLE && !dout_en));
endmodule

bind burst_sram_ctrl bsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .adv_n         (adv_n),
    .sel0_n        (sel0_n),
    .sel1          (sel1),
    .sel2_n        (sel2_n),
    .glob_wr_n     (glob_wr_n),
    .byte_wr_en_n  (byte_wr_en_n),
    .lane_sel_n    (lane_sel_n),
    .oe_n          (oe_n),
    .dout_en       (dout_en),
    .cur_off       (cur_off),
    .fsm_state     (fsm_state)
);

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctrl_bench;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          proc_strobe_n, ctrl_strobe_n, adv_n;
    logic          sel0_n, sel1, sel2_n;
    logic          glob_wr_n, byte_wr_en_n;
    logic [3:0]    lane_sel_n;
    logic          burst_ilv, oe_n;
    logic [31:0]   din, dout;
    logic          dout_en;

    logic [31:0] model [NW];
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    burst_sram_ctrl u_burst_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .proc_strobe_n(proc_strobe_n), .ctrl_strobe_n(ctrl_strobe_n),
        .adv_n(adv_n), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .glob_wr_n(glob_wr_n), .byte_wr_en_n(byte_wr_en_n),
        .lane_sel_n(lane_sel_n), .burst_ilv(burst_ilv), .oe_n(oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; adv_n = 1'b1;
        sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
        glob_wr_n = 1'b1; byte_wr_en_n = 1'b1; lane_sel_n = 4'hF;
        oe_n = 1'b0; din = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] pat(input int a);
        return 32'hA5000000 ^ (a * 32'h01030507);
    endfunction

    function automatic int beat_addr(input int a, input int n, input bit ilv);
        int lo;
        lo = a & 3;
        return (a & ~3) | (ilv ? (lo ^ n) : ((lo + n) & 3));
    endfunction

    // controller-strobe start with write: stores din on this edge (R6)
    task automatic cwrite(input int a, input logic [31:0] d);
        quiet();
        ctrl_strobe_n = 1'b0; addr = AW'(a); din = d; glob_wr_n = 1'b0;
        tick();
        model[a] = d;
        quiet();
    endtask

    // start a read burst, then four beats with adv low
    task automatic burst(input int a, input bit ilv, input bit use_proc, input string req);
        quiet();
        addr = AW'(a); burst_ilv = ilv;
        if (use_proc) proc_strobe_n = 1'b0; else ctrl_strobe_n = 1'b0;
        tick();
        quiet();
        adv_n = 1'b0;
        for (int n = 0; n < 4; n++) begin
            tick();
            chk(req, {31'd0, dout_en}, 32'd1);
            chk(req, dout, model[beat_addr(a, n, ilv)]);
        end
        quiet();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        quiet();
        addr = '0; burst_ilv = 1'b1; rst_n = 1'b0;
        tick(); tick();
        chk("R14 reset", {31'd0, dout_en}, 32'd0);
        rst_n = 1'b1;
        tick();
        chk("R14 after reset", {31'd0, dout_en}, 32'd0);

        for (int a = 0; a < NW; a++) cwrite(a, pat(a));

        // R6: written word visible on next edge
        cwrite(20, 32'h1234_5678);
        tick();
        chk("R6 same-edge write", dout, 32'h1234_5678);

        // R8 / R9 / R7: every start address, both orders, both strobes
        for (int a = 0; a < NW; a++) begin
            burst(a, 1'b0, 1'b1, "R8 linear");
            burst(a, 1'b1, 1'b1, "R9 interleaved");
        end
        for (int a = 0; a < 8; a++) burst(a, a[0], 1'b0, "R4 ctrl read");

        // R7: adv high holds the offset
        quiet(); addr = AW'(6); burst_ilv = 1'b0; proc_strobe_n = 1'b0;
        tick(); quiet();
        tick(); chk("R7 hold beat0", dout, model[6]);
        tick(); chk("R7 hold again", dout, model[6]);
        adv_n = 1'b0;
        tick(); chk("R7 step", dout, model[6]);
        tick(); chk("R7 step wrap group", dout, model[7]);
        tick(); chk("R7 wrap", dout, model[4]);

        // R13 / R12: combinational tristate
        oe_n = 1'b1; #1;
        chk("R13 oe high", {31'd0, dout_en}, 32'd0);
        oe_n = 1'b0; #1;
        chk("R13 oe low", {31'd0, dout_en}, 32'd1);
        byte_wr_en_n = 1'b0; lane_sel_n = 4'hE; #1;
        chk("R12 byte write", {31'd0, dout_en}, 32'd0);
        byte_wr_en_n = 1'b1; glob_wr_n = 1'b0; #1;
        chk("R12 global write", {31'd0, dout_en}, 32'd0);
        glob_wr_n = 1'b1; byte_wr_en_n = 1'b0; lane_sel_n = 4'hF; #1;
        chk("R12 no lane", {31'd0, dout_en}, 32'd1);
        quiet();

        // R5: write inputs ignored at processor start, taken at next edge
        quiet(); addr = AW'(11); proc_strobe_n = 1'b0; glob_wr_n = 1'b0; din = 32'hDEAD_0000;
        tick(); quiet();
        tick(); chk("R5 start write ignored", dout, model[11]);
        quiet(); addr = AW'(10); proc_strobe_n = 1'b0; glob_wr_n = 1'b0; din = 32'hDEAD_1111;
        tick(); quiet();
        glob_wr_n = 1'b0; din = 32'hBEEF_0010;
        tick(); model[10] = 32'hBEEF_0010; quiet();
        tick(); chk("R5 second-edge write", dout, model[10]);

        // R10: global write overrides inactive byte selects
        quiet(); ctrl_strobe_n = 1'b0; addr = AW'(28); din = 32'h0BAD_F00D; glob_wr_n = 1'b0;
        byte_wr_en_n = 1'b1; lane_sel_n = 4'hF;
        tick(); model[28] = 32'h0BAD_F00D; quiet();
        tick(); chk("R10 global all lanes", dout, model[28]);
        quiet(); ctrl_strobe_n = 1'b0; addr = AW'(29); din = 32'hFEED_C0DE; glob_wr_n = 1'b0;
        byte_wr_en_n = 1'b0; lane_sel_n = 4'hE;
        tick(); model[29] = 32'hFEED_C0DE; quiet();
        tick(); chk("R10 global over byte", dout, model[29]);

        // R11: every lane mask
        for (int m = 0; m < 16; m++) begin
            logic [31:0] nd, ex;
            nd = ~model[30] ^ (m * 32'h0101_0101);
            ex = model[30];
            for (int k = 0; k < 4; k++) if (m[k]) ex[k*8 +: 8] = nd[k*8 +: 8];
            quiet(); ctrl_strobe_n = 1'b0; addr = AW'(30); din = nd;
            byte_wr_en_n = 1'b0; lane_sel_n = ~4'(m);
            tick(); model[30] = ex; quiet();
            tick(); chk("R11 lane mask", dout, ex);
        end

        // R1: deselect, later writes ignored
        quiet(); ctrl_strobe_n = 1'b0; sel2_n = 1'b1; addr = AW'(41); glob_wr_n = 1'b0; din = 32'h1;
        tick(); quiet();
        glob_wr_n = 1'b0; din = 32'h2;
        tick(); quiet();
        tick(); chk("R1 deselected", {31'd0, dout_en}, 32'd0);
        quiet(); ctrl_strobe_n = 1'b0; sel1 = 1'b0; addr = AW'(42); tick(); quiet();
        tick(); chk("R1 sel1 low", {31'd0, dout_en}, 32'd0);
        burst(40, 1'b0, 1'b0, "R1 no stray write");

        // R2: processor strobe ignored with sel0_n high (block idle beforehand)
        quiet(); ctrl_strobe_n = 1'b0; sel1 = 1'b0; tick(); quiet();
        proc_strobe_n = 1'b0; sel0_n = 1'b1; addr = AW'(44);
        tick(); quiet();
        tick(); chk("R2 no start", {31'd0, dout_en}, 32'd0);

        // R3: controller strobe ignored while processor strobe low
        quiet(); proc_strobe_n = 1'b0; ctrl_strobe_n = 1'b0; addr = AW'(50);
        glob_wr_n = 1'b0; din = 32'h5555_AAAA;
        tick(); quiet();
        tick(); chk("R3 ctrl ignored", dout, model[50]);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule